// File: doc/BRIEF.md
# Ethernet PHY Management Register Model

This block models the management register set of one Ethernet PHY as it is seen from a MAC. Software writes a 32-bit management frame word. The block decodes that word into a read or a write of one 16-bit PHY register and performs the access. A read places the register value in the low half of the frame word, where software collects it. Each access, read or write, raises a sticky done flag, which software clears with a separate pulse.

The modelled PHY holds five registers: control, status, advertisement, interrupt source and interrupt mask. A `link_up` input stands in for the cable. When it changes, the model updates the link bits of the status register and records an interrupt cause. Autonegotiation finishes in the same step, with no delay. The interrupt source clears when it is read. The PHY interrupt output stays asserted while any recorded cause is also enabled in the mask.

A small controller sequences the work through three named states:
- `ST_LINK` applies the current link level to the registers. It is the state entered from reset.
- `ST_IDLE` accepts a new frame. It also detects a link level that differs from the one last applied.
- `ST_ACCESS` performs the decoded register access and raises the done flag.

The transitions are:
- LINK→IDLE, always.
- IDLE→ACCESS on a frame write.
- IDLE→LINK when the link level has changed and no frame write is present.
- ACCESS→LINK after a control write that requests a PHY reset.
- ACCESS→IDLE otherwise.

Top module: `phy_mgmt_model`

## Requirements
- R1: After reset, with `link_up` high, the registers read as follows: control 0x3000, status 0x782D, advertisement 0x01E1, interrupt mask 0, interrupt source 0x00C0. `busy`, `done_flag` and `phy_irq` are low once the first link step has finished.
- R2: The frame word is decoded as follows. Bit 29 set selects a read. Bits 27..18 give the PHY register number. Bits 15..0 give the write data. A read replaces bits 15..0 of `frame_q` with the register value and leaves bits 31..16 as written. A write leaves `frame_q` equal to the written word.
- R3: Every access sets `done_flag` in the cycle that performs it. A `done_clr` pulse clears the flag. If a set and a clear fall in the same cycle, the set wins.
- R4: A write of register 0 with bit 15 set returns all five registers to their reset values and then applies the link level again. Any other write of register 0 stores data AND 0x7980. If bit 12 of that data is set, the write also sets status bit 5.
- R5: When the link goes up, status bits 0x0024 are set and interrupt source bits 7 (energy present) and 6 (autonegotiation done) are set. When the link goes down, status bits 0x0024 clear and interrupt source bit 4 (link lost) is set. Interrupt source bits accumulate until they are read.
- R6: A read of register 29 returns the interrupt source and clears it to zero.
- R7: Register 30, the interrupt mask, keeps only bits 7..0 of the written data. Bits 15..8 read as zero.
- R8: A write to a register number above 31 changes nothing, including the registers whose number equals it modulo 32. Writes to register 1 and to unimplemented numbers are ignored. Reads of unimplemented numbers and of numbers above 31 return 0.
- R9: `phy_irq` is high exactly when the interrupt source AND the interrupt mask is nonzero.
- R10: While `busy` is high, a frame write is ignored. It neither starts an access nor changes `frame_q`.
- R11: Register 4, the advertisement, stores all 16 bits of the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_wr | input | 1 | Frame word write strobe, one cycle |
| frame_wdata | input | 32 | Frame word written by software |
| done_clr | input | 1 | Clears the done flag |
| link_up | input | 1 | Cable link level, synchronous to clk |
| frame_q | output | 32 | Frame register contents, with read data in bits 15..0 |
| done_flag | output | 1 | Sticky access-complete flag |
| busy | output | 1 | Controller is not idle, so frame writes are ignored |
| phy_irq | output | 1 | PHY interrupt request |

## Verification
The assertions take for granted that `link_up` is already synchronous to `clk` and that a frame write lasts a single cycle. They also assume software waits for `busy` to fall before writing another frame. The bench therefore changes `link_up` and drives strobes only on falling edges. It issues every access through one task that waits out `busy`. The one deliberate exception is a frame strobe placed inside a link step, which tests R10. The sweeps cover all 32 register numbers, all 256 mask values and 31 aliased numbers above 31. The expected values come from the requirement constants.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int FRAME_W  = 32;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 10;
    localparam int NUM_REGS = 32;
    localparam int RD_BIT   = 29;
    localparam int ADDR_LSB = 18;

    typedef enum logic [1:0] {
        ST_LINK   = 2'd0,
        ST_IDLE   = 2'd1,
        ST_ACCESS = 2'd2
    } mgmt_state_e;

    localparam int REG_CTRL  = 0;
    localparam int REG_STAT  = 1;
    localparam int REG_ADV   = 4;
    localparam int REG_ISRC  = 29;
    localparam int REG_IMASK = 30;

    localparam logic [15:0] CTRL_RST_VAL  = 16'h3000;
    localparam logic [15:0] STAT_RST_VAL  = 16'h7809;
    localparam logic [15:0] ADV_RST_VAL   = 16'h01E1;
    localparam logic [15:0] CTRL_KEEP     = 16'h7980;
    localparam logic [15:0] IMASK_KEEP    = 16'h00FF;
    localparam logic [15:0] STAT_LINK     = 16'h0024;
    localparam logic [15:0] STAT_ANEG     = 16'h0020;
    localparam logic [15:0] INT_DOWN      = 16'h0010;
    localparam logic [15:0] INT_UP        = 16'h00C0;
    localparam int          CTRL_SRST_BIT = 15;
    localparam int          CTRL_ANEG_BIT = 12;

endpackage

// File: rtl/phy_mgmt_fsm.sv
module phy_mgmt_fsm
    import phy_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_wr,
    input  logic        link_change,
    input  logic        soft_rst,
    output mgmt_state_e state,
    output logic        busy,
    output logic        acc_en,
    output logic        link_eval,
    output logic        frame_take
);

    mgmt_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_LINK;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LINK:   st_d = ST_IDLE;
            ST_IDLE: begin
                if (frame_wr)         st_d = ST_ACCESS;
                else if (link_change) st_d = ST_LINK;
            end
            ST_ACCESS: st_d = soft_rst ? ST_LINK : ST_IDLE;
            default:   st_d = ST_LINK;
        endcase
    end

    always_comb begin
        state      = st_q;
        busy       = (st_q != ST_IDLE);
        acc_en     = (st_q == ST_ACCESS);
        link_eval  = (st_q == ST_LINK);
        frame_take = (st_q == ST_IDLE) && frame_wr;
    end

endmodule

// File: rtl/phy_reg_file.sv
module phy_reg_file
    import phy_mgmt_pkg::*;
#(
    parameter int P_DATA_W   = DATA_W,
    parameter int P_ADDR_W   = ADDR_W,
    parameter int P_NUM_REGS = NUM_REGS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_en,
    input  logic                acc_rd,
    input  logic [P_ADDR_W-1:0] acc_addr,
    input  logic [P_DATA_W-1:0] acc_wdata,
    input  logic                link_eval,
    input  logic                link_up,
    output logic [P_DATA_W-1:0] rd_data,
    output logic                soft_rst,
    output logic                link_seen,
    output logic                irq,
    output logic [P_DATA_W-1:0] ctrl_q,
    output logic [P_DATA_W-1:0] stat_q,
    output logic [P_DATA_W-1:0] adv_q,
    output logic [P_DATA_W-1:0] isrc_q,
    output logic [P_DATA_W-1:0] imask_q
);

    localparam int IDX_W = $clog2(P_NUM_REGS);
    localparam logic [IDX_W-1:0] IDX_CTRL  = IDX_W'(REG_CTRL);
    localparam logic [IDX_W-1:0] IDX_STAT  = IDX_W'(REG_STAT);
    localparam logic [IDX_W-1:0] IDX_ADV   = IDX_W'(REG_ADV);
    localparam logic [IDX_W-1:0] IDX_ISRC  = IDX_W'(REG_ISRC);
    localparam logic [IDX_W-1:0] IDX_IMASK = IDX_W'(REG_IMASK);

    logic             in_range;
    logic [IDX_W-1:0] idx;
    logic             wr_hit;

    assign in_range = (acc_addr < P_ADDR_W'(P_NUM_REGS));
    assign idx      = acc_addr[IDX_W-1:0];
    assign wr_hit   = acc_en && !acc_rd && in_range;
    assign soft_rst = wr_hit && (idx == IDX_CTRL) && acc_wdata[CTRL_SRST_BIT];
    assign irq      = |(isrc_q & imask_q);

    always_comb begin
        rd_data = '0;
        if (in_range) begin
            case (idx)
                IDX_CTRL:  rd_data = ctrl_q;
                IDX_STAT:  rd_data = stat_q;
                IDX_ADV:   rd_data = adv_q;
                IDX_ISRC:  rd_data = isrc_q;
                IDX_IMASK: rd_data = imask_q;
                default:   rd_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl_q  <= P_DATA_W'(CTRL_RST_VAL);
            stat_q  <= P_DATA_W'(STAT_RST_VAL);
            adv_q   <= P_DATA_W'(ADV_RST_VAL);
            isrc_q  <= '0;
            imask_q <= '0;
            if (!rst_n) link_seen <= 1'b0;
        end else if (link_eval) begin
            link_seen <= link_up;
            if (link_up) begin
                stat_q <= stat_q | P_DATA_W'(STAT_LINK);
                isrc_q <= isrc_q | P_DATA_W'(INT_UP);
            end else begin
                stat_q <= stat_q & ~P_DATA_W'(STAT_LINK);
                isrc_q <= isrc_q | P_DATA_W'(INT_DOWN);
            end
        end else if (acc_en && in_range) begin
            if (acc_rd) begin
                if (idx == IDX_ISRC) isrc_q <= '0;
            end else begin
                case (idx)
                    IDX_CTRL: begin
                        ctrl_q <= acc_wdata & P_DATA_W'(CTRL_KEEP);
                        if (acc_wdata[CTRL_ANEG_BIT])
                            stat_q <= stat_q | P_DATA_W'(STAT_ANEG);
                    end
                    IDX_ADV:   adv_q   <= acc_wdata;
                    IDX_IMASK: imask_q <= acc_wdata & P_DATA_W'(IMASK_KEEP);
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/phy_mgmt_model.sv
module phy_mgmt_model
    import phy_mgmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_wr,
    input  logic [FRAME_W-1:0] frame_wdata,
    input  logic               done_clr,
    input  logic               link_up,
    output logic [FRAME_W-1:0] frame_q,
    output logic               done_flag,
    output logic               busy,
    output logic               phy_irq
);

    mgmt_state_e       st_q;
    logic              acc_en, link_eval, frame_take, soft_rst, link_seen;
    logic [DATA_W-1:0] rd_data, ctrl_q, stat_q, adv_q, isrc_q, imask_q;
    logic              f_rd;
    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_data;

    assign f_rd   = frame_q[RD_BIT];
    assign f_addr = frame_q[ADDR_LSB +: ADDR_W];
    assign f_data = frame_q[DATA_W-1:0];

    phy_mgmt_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_wr    (frame_wr),
        .link_change (link_up != link_seen),
        .soft_rst    (soft_rst),
        .state       (st_q),
        .busy        (busy),
        .acc_en      (acc_en),
        .link_eval   (link_eval),
        .frame_take  (frame_take)
    );

    phy_reg_file u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_rd    (f_rd),
        .acc_addr  (f_addr),
        .acc_wdata (f_data),
        .link_eval (link_eval),
        .link_up   (link_up),
        .rd_data   (rd_data),
        .soft_rst  (soft_rst),
        .link_seen (link_seen),
        .irq       (phy_irq),
        .ctrl_q    (ctrl_q),
        .stat_q    (stat_q),
        .adv_q     (adv_q),
        .isrc_q    (isrc_q),
        .imask_q   (imask_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (frame_take) begin
            frame_q <= frame_wdata;
        end else if (acc_en && f_rd) begin
            frame_q[DATA_W-1:0] <= rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        done_flag <= 1'b0;
        else if (acc_en)   done_flag <= 1'b1;
        else if (done_clr) done_flag <= 1'b0;
    end

endmodule

// File: rtl/phy_mgmt_checker.sv
module phy_mgmt_checker
    import phy_mgmt_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input mgmt_state_e        state,
    input logic               link_up,
    input logic [FRAME_W-1:0] frame_q,
    input logic               done_flag,
    input logic               phy_irq,
    input logic [DATA_W-1:0]  ctrl_q,
    input logic [DATA_W-1:0]  stat_q,
    input logic [DATA_W-1:0]  isrc_q,
    input logic [DATA_W-1:0]  imask_q
);

    p_done_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ACCESS |=> done_flag);

    p_ctrl_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_KEEP) == '0);

    p_link_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LINK) && link_up |=> (stat_q & STAT_LINK) == STAT_LINK);

    p_src_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS) && frame_q[RD_BIT]
        && (frame_q[ADDR_LSB +: ADDR_W] == ADDR_W'(REG_ISRC)) |=> isrc_q == '0);

    p_mask_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        imask_q[DATA_W-1:8] == '0);

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        phy_irq |-> (imask_q != '0) && (isrc_q != '0));

    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_LINK |=> $stable(frame_q));

endmodule

bind phy_mgmt_model phy_mgmt_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (st_q),
    .link_up   (link_up),
    .frame_q   (frame_q),
    .done_flag (done_flag),
    .phy_irq   (phy_irq),
    .ctrl_q    (ctrl_q),
    .stat_q    (stat_q),
    .isrc_q    (isrc_q),
    .imask_q   (imask_q)
);

// File: tb/phy_mgmt_model_tb.sv
module phy_mgmt_model_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_wr = 1'b0;
    logic [31:0] frame_wdata = '0;
    logic        done_clr = 1'b0;
    logic        link_up = 1'b1;
    logic [31:0] frame_q;
    logic        done_flag, busy, phy_irq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    phy_mgmt_model dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_wr    (frame_wr),
        .frame_wdata (frame_wdata),
        .done_clr    (done_clr),
        .link_up     (link_up),
        .frame_q     (frame_q),
        .done_flag   (done_flag),
        .busy        (busy),
        .phy_irq     (phy_irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] mk_frame(input bit rd, input int addr, input logic [15:0] d);
        return (32'(rd) << 29) | ((32'(addr) & 32'h3FF) << 18) | 32'(d);
    endfunction

    task automatic op(input logic [31:0] fr, output logic [31:0] fq);
        @(negedge clk);
        frame_wr    = 1'b1;
        frame_wdata = fr;
        @(negedge clk);
        frame_wr = 1'b0;
        while (busy) @(negedge clk);
        fq = frame_q;
    endtask

    task automatic rd(input int addr, output logic [15:0] v);
        logic [31:0] fq;
        op(mk_frame(1'b1, addr, 16'h0000), fq);
        v = fq[15:0];
    endtask

    task automatic wr(input int addr, input logic [15:0] d);
        logic [31:0] fq;
        op(mk_frame(1'b0, addr, d), fq);
    endtask

    task automatic set_link(input bit up);
        @(negedge clk);
        link_up = up;
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] v;
        logic [31:0] fq;
        logic [31:0] prev;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state at the ports
        check("R1 busy", {31'b0, busy}, 32'h0);
        check("R1 done", {31'b0, done_flag}, 32'h0);
        check("R9 irq with zero mask", {31'b0, phy_irq}, 32'h0);

        // R1 R8 sweep of all register numbers after reset
        for (int a = 0; a < 32; a++) begin
            logic [15:0] e;
            case (a)
                0:       e = 16'h3000;
                1:       e = 16'h782D;
                4:       e = 16'h01E1;
                29:      e = 16'h00C0;
                default: e = 16'h0000;
            endcase
            rd(a, v);
            check($sformatf("R1 reset read reg %0d", a), {16'h0, v}, {16'h0, e});
        end
        check("R3 done after access", {31'b0, done_flag}, 32'h1);

        // R2 frame layout: upper bits kept on read, whole word kept on write
        op(32'hC000_0000 | mk_frame(1'b1, 4, 16'hABCD), fq);
        check("R2 read frame", fq, 32'hC000_0000 | mk_frame(1'b1, 4, 16'h01E1));
        op(32'h9003_0000 | mk_frame(1'b0, 5, 16'h5A5A), fq);
        check("R2 write frame", fq, 32'h9003_0000 | mk_frame(1'b0, 5, 16'h5A5A));

        // R3 clear and set-wins
        @(negedge clk);
        done_clr = 1'b1;
        @(negedge clk);
        check("R3 cleared", {31'b0, done_flag}, 32'h0);
        rd(0, v);
        check("R3 set wins over clear", {31'b0, done_flag}, 32'h1);
        @(negedge clk);
        done_clr = 1'b0;

        // R6 source already cleared by earlier read
        rd(29, v);
        check("R6 cleared on read", {16'h0, v}, 32'h0);

        // R5 link down then up
        set_link(1'b0);
        rd(1, v);
        check("R5 status down", {16'h0, v}, 32'h7809);
        rd(29, v);
        check("R5 source down", {16'h0, v}, 32'h0010);
        // R4 autonegotiation done bit from control write
        wr(0, 16'h1000);
        rd(1, v);
        check("R4 aneg sets status bit 5", {16'h0, v}, 32'h7829);
        set_link(1'b1);
        rd(1, v);
        check("R5 status up", {16'h0, v}, 32'h782D);

        // R5 accumulation: source now 0xC0 (not read). R9 R7 mask sweep
        for (int m = 0; m < 256; m++) begin
            wr(30, 16'h5A00 | 16'(m));
            check($sformatf("R9 irq mask %0d", m), {31'b0, phy_irq},
                  {31'b0, ((m & 8'hC0) != 0)});
            if ((m % 16) == 15) begin
                rd(30, v);
                check($sformatf("R7 mask %0d", m), {16'h0, v}, 32'(m));
            end
        end

        // R8 register numbers above 31 alias nothing
        for (int k = 1; k < 32; k++) begin
            wr(30 + 32 * k, 16'h0000);
            wr(32 * k, 16'h8000);
            rd(30, v);
            check($sformatf("R8 alias %0d", k), {16'h0, v}, 32'h00FF);
        end
        rd(40, v);
        check("R8 read above 31", {16'h0, v}, 32'h0);
        wr(1, 16'h0000);
        rd(1, v);
        check("R8 status write ignored", {16'h0, v}, 32'h782D);
        wr(5, 16'hFFFF);
        rd(5, v);
        check("R8 unimplemented write", {16'h0, v}, 32'h0);

        // R4 control mask sweep over single bits
        for (int i = 0; i < 15; i++) begin
            wr(0, 16'(1) << i);
            rd(0, v);
            check($sformatf("R4 control bit %0d", i), {16'h0, v},
                  {16'h0, (16'(1) << i) & 16'h7980});
        end

        // R11 advertisement
        wr(4, 16'hFFFF);
        rd(4, v);
        check("R11 adv all ones", {16'h0, v}, 32'hFFFF);
        wr(4, 16'h1234);
        rd(4, v);
        check("R11 adv pattern", {16'h0, v}, 32'h1234);

        // R4 soft reset
        wr(30, 16'h0010);
        wr(0, 16'h8000);
        rd(0, v);
        check("R4 soft reset ctrl", {16'h0, v}, 32'h3000);
        rd(4, v);
        check("R4 soft reset adv", {16'h0, v}, 32'h01E1);
        rd(30, v);
        check("R4 soft reset mask", {16'h0, v}, 32'h0);
        rd(1, v);
        check("R4 soft reset status", {16'h0, v}, 32'h782D);
        rd(29, v);
        check("R4 soft reset source", {16'h0, v}, 32'h00C0);

        // R10 frame write during a link step is ignored
        prev = frame_q;
        @(negedge clk);
        link_up = 1'b0;
        @(negedge clk);
        check("R10 busy in link step", {31'b0, busy}, 32'h1);
        frame_wr    = 1'b1;
        frame_wdata = mk_frame(1'b0, 4, 16'h0BAD);
        @(negedge clk);
        frame_wr = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 frame unchanged", frame_q, prev);
        rd(4, v);
        check("R10 adv unchanged", {16'h0, v}, 32'h01E1);

        summary();
    end

endmodule